// File: doc/BRIEF.md
# Indexed Register Window Bridge

This block connects a narrow host bus with an active-low chip select to a larger set of internal 32-bit registers. The host sees only two locations: an index location and a data window. Writing the index chooses which internal register the window reaches. Later window reads and writes move one byte of that register per access, and the low address bits pick the byte.

Behind the window are four kinds of register. The identification register holds a small writable field. The version register and the arbitration register are read-only. The halves of an external redirection table hold the rest. The bridge does not store the table itself. It reaches the table through a word port: a word address, a combinational read word and a one-cycle write enable. A byte write to the window becomes a read-modify-write of a whole table word.

Top module: `idxwin_bridge`

## Requirements
- R1: After reset the index register holds 0, and the identification field holds 0.
- R2: A write with `winSel`=0 and `addr`=0 loads the index register. A read with `winSel`=0 and `addr`=0 returns the index. The other three byte lanes of the index location read 0, and writes to them are ignored.
- R3: Index 0x00 selects the identification register. Only bits [27:24] are stored, from the low nibble of a byte-lane 3 write. All other bits read 0.
- R4: Index 0x01 selects the version register, which reads 0x00170011: version 0x11 in bits [7:0] and maximum entry number 23 in bits [23:16]. Writes to it are ignored.
- R5: Index 0x02 selects the arbitration register. It is read-only and shows the identification field in bits [27:24], with zeros elsewhere.
- R6: Indices 0x10 to 0x3F drive `tblAddr` = index − 0x10, so an even index gives the low half of an entry. A window read returns byte lane `addr` of `tblRdData`, where lane n is bits [8n+7:8n].
- R7: A window write to a table index pulses `tblWrEn` for the cycle in which the strobe is sampled. `tblWrData` equals `tblRdData` with lane `addr` replaced by `wrData`.
- R8: Indices that are not assigned, such as 0x05 or 0x40, read 0 in every lane. Writes to them change no register and raise no `tblWrEn`.
- R9: A write takes effect at the rising clock edge where `csN` and `wrN` are both sampled low. With `csN` high, nothing changes.
- R10: `rdData` is 0 unless `csN` and `rdN` are low and `wrN` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| winSel | input | 1 | 0 selects the index location, 1 selects the data window |
| addr | input | 2 | Byte lane of the selected register |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte, 0 when not reading |
| tblAddr | output | 6 | Table word address (index − 0x10) |
| tblWrEn | output | 1 | One-cycle table word write enable |
| tblWrData | output | 32 | Merged table write word |
| tblRdData | input | 32 | Table word at `tblAddr`, combinational |

## Verification
The bench builds the block with its default parameters: 24 entries, an 8-bit index, table base 0x10 and version 0x11. With these values the table range ends exactly at index 0x3F, so the last table half and the first unassigned index past it (0x40) can both be reached with single index writes. The default version and entry count give a fixed read-only word to compare byte by byte. A behavioural table memory in the bench lets byte-merge writes be observed through later window reads. The bench also counts every `tblWrEn` pulse, so a write with no effect on the table can be seen at the ports.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

  typedef enum logic [2:0] {
    T_ID   = 3'd0,
    T_VER  = 3'd1,
    T_ARB  = 3'd2,
    T_TBL  = 3'd3,
    T_NONE = 3'd4
  } tgt_t;

  typedef struct packed {
    logic idxWe;
    logic idxRe;
    logic winWe;
    logic winRe;
    tgt_t tgt;
  } strobe_t;

endpackage

// File: rtl/idxwin_ctrl.sv
module idxwin_ctrl
  import idxwin_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int ENTRIES  = 24,
  parameter int TBL_BASE = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             winSel,
  input  logic [IDX_W-1:0] indexReg,
  output strobe_t          strb
);
  localparam logic [IDX_W-1:0] TBL_LO = IDX_W'(TBL_BASE);
  localparam logic [IDX_W-1:0] TBL_HI = IDX_W'(TBL_BASE + 2 * ENTRIES - 1);

  logic wrAct;
  logic rdAct;

  always_comb begin
    wrAct = !csN && !wrN;
    rdAct = !csN && !rdN && wrN;
    strb.idxWe = wrAct && !winSel;
    strb.idxRe = rdAct && !winSel;
    strb.winWe = wrAct && winSel;
    strb.winRe = rdAct && winSel;
    if (indexReg == IDX_W'(0))                              strb.tgt = T_ID;
    else if (indexReg == IDX_W'(1))                         strb.tgt = T_VER;
    else if (indexReg == IDX_W'(2))                         strb.tgt = T_ARB;
    else if (indexReg >= TBL_LO && indexReg <= TBL_HI)      strb.tgt = T_TBL;
    else                                                    strb.tgt = T_NONE;
  end

  // R10: a read and a write never both act in one cycle
  p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.idxWe, strb.idxRe, strb.winWe, strb.winRe}));

endmodule

// File: rtl/idxwin_dpath.sv
module idxwin_dpath
  import idxwin_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 8,
  parameter int REG_W    = 32,
  parameter int ENTRIES  = 24,
  parameter int TBL_BASE = 16,
  parameter int VERSION  = 17,
  parameter int ID_LSB   = 24,
  parameter int ID_W     = 4,
  parameter int MAXE_LSB = 16,
  localparam int LANES   = REG_W / DATA_W,
  localparam int LANE_W  = $clog2(LANES),
  localparam int TA_W    = $clog2(2 * ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [LANE_W-1:0] lane,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  indexReg,
  output logic [TA_W-1:0]   tblAddr,
  output logic              tblWrEn,
  output logic [REG_W-1:0]  tblWrData,
  input  logic [REG_W-1:0]  tblRdData
);
  localparam logic [IDX_W-1:0] TBL_LO = IDX_W'(TBL_BASE);

  logic [ID_W-1:0]   idReg;
  logic [REG_W-1:0]  idWord;
  logic [REG_W-1:0]  verWord;
  logic [REG_W-1:0]  selWord;
  logic [REG_W-1:0]  idMerged;
  logic [DATA_W-1:0] winByte;

  always_comb begin
    idWord = '0;
    idWord[ID_LSB +: ID_W] = idReg;
    verWord = '0;
    verWord[DATA_W-1:0] = DATA_W'(VERSION);
    verWord[MAXE_LSB +: DATA_W] = DATA_W'(ENTRIES - 1);
  end

  // byte-lane merge for table and identification writes
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign tblWrData[g*DATA_W +: DATA_W] =
      (lane == LANE_W'(g)) ? wrData : tblRdData[g*DATA_W +: DATA_W];
    assign idMerged[g*DATA_W +: DATA_W] =
      (lane == LANE_W'(g)) ? wrData : idWord[g*DATA_W +: DATA_W];
  end

  assign tblAddr = TA_W'(indexReg - TBL_LO);
  assign tblWrEn = strb.winWe && (strb.tgt == T_TBL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexReg <= '0;
      idReg    <= '0;
    end else begin
      if (strb.idxWe && lane == '0) indexReg <= wrData[IDX_W-1:0];
      if (strb.winWe && strb.tgt == T_ID) idReg <= idMerged[ID_LSB +: ID_W];
    end
  end

  always_comb begin
    unique case (strb.tgt)
      T_ID:    selWord = idWord;
      T_VER:   selWord = verWord;
      T_ARB:   selWord = idWord;
      T_TBL:   selWord = tblRdData;
      default: selWord = '0;
    endcase
    winByte = selWord[lane*DATA_W +: DATA_W];
    if (strb.winRe)                     rdData = winByte;
    else if (strb.idxRe && lane == '0)  rdData = DATA_W'(indexReg);
    else                                rdData = '0;
  end

  // R9: index changes only on an index write strobe
  p_index_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.idxWe |=> $stable(indexReg));

  // R3: identification field changes only on a window write to it
  p_id_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.winWe && strb.tgt == T_ID) |=> $stable(idReg));

  // R4: version byte lane 0 is constant
  p_ver_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.winRe && strb.tgt == T_VER && lane == '0) |-> rdData == DATA_W'(VERSION));

endmodule

// File: rtl/idxwin_bridge.sv
module idxwin_bridge
  import idxwin_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int DATA_W   = 8,
  parameter int REG_W    = 32,
  parameter int ENTRIES  = 24,
  parameter int TBL_BASE = 16,
  parameter int VERSION  = 17,
  localparam int LANE_W  = $clog2(REG_W / DATA_W),
  localparam int TA_W    = $clog2(2 * ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              winSel,
  input  logic [LANE_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [TA_W-1:0]   tblAddr,
  output logic              tblWrEn,
  output logic [REG_W-1:0]  tblWrData,
  input  logic [REG_W-1:0]  tblRdData
);
  strobe_t          strb;
  logic [IDX_W-1:0] indexReg;

  idxwin_ctrl #(
    .IDX_W(IDX_W), .ENTRIES(ENTRIES), .TBL_BASE(TBL_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .winSel(winSel), .indexReg(indexReg), .strb(strb)
  );

  idxwin_dpath #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .REG_W(REG_W), .ENTRIES(ENTRIES),
    .TBL_BASE(TBL_BASE), .VERSION(VERSION)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .lane(addr), .wrData(wrData),
    .rdData(rdData), .indexReg(indexReg), .tblAddr(tblAddr),
    .tblWrEn(tblWrEn), .tblWrData(tblWrData), .tblRdData(tblRdData)
  );

  // R7: table write only under an active window write
  p_tbl_wr_bus_r7: assert property (@(posedge clk) disable iff (!rstN)
    tblWrEn |-> (!csN && !wrN && winSel));

  // R7: lane 0 of the word is kept when another lane is written
  p_rmw_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tblWrEn && addr != '0) |-> tblWrData[DATA_W-1:0] == tblRdData[DATA_W-1:0]);

endmodule

// File: tb/idxwin_bridge_test.sv
module idxwin_bridge_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rdN = 1'b1, wrN = 1'b1, winSel = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [5:0]  tblAddr;
  logic        tblWrEn;
  logic [31:0] tblWrData;
  logic [31:0] tblRdData;
  logic [31:0] mem [48];

  int checks = 0, fails = 0, wrPulses = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  event sampleEv;

  always #2 clk = ~clk;

  idxwin_bridge uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .winSel(winSel),
    .addr(addr), .wrData(wrData), .rdData(rdData), .tblAddr(tblAddr),
    .tblWrEn(tblWrEn), .tblWrData(tblWrData), .tblRdData(tblRdData)
  );

  assign tblRdData = (tblAddr < 6'd48) ? mem[tblAddr] : 32'h0;

  initial for (int i = 0; i < 48; i++) mem[i] = 32'h0;

  always @(posedge clk) begin
    if (tblWrEn) begin
      mem[tblAddr] <= tblWrData;
      wrPulses <= wrPulses + 1;
    end
  end

  // monitor: pop expected items and compare
  initial forever begin
    @(sampleEv);
    while (expQ.size() > 0) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (rdData !== e) begin
        fails++;
        $display("FAIL %s: rdData=%02h expected=%02h", t, rdData, e);
      end
    end
  end

  task automatic busWrite(input logic sel, input logic [1:0] lane,
                          input logic [7:0] d, input logic cs = 1'b1);
    @(negedge clk);
    csN = !cs; wrN = 1'b0; winSel = sel; addr = lane; wrData = d;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic busRead(input logic sel, input logic [1:0] lane,
                         input logic [7:0] e, input string tag,
                         input logic rdOn = 1'b1);
    @(negedge clk);
    csN = 1'b0; rdN = !rdOn; winSel = sel; addr = lane;
    #1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    -> sampleEv;
    #1;
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic setIndex(input logic [7:0] ix);
    busWrite(1'b0, 2'd0, ix);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    busRead(1'b0, 2'd0, 8'h00, "R1 index after reset");
    busRead(1'b1, 2'd3, 8'h00, "R1 id after reset");
    // R2: index write/read and upper lanes
    setIndex(8'h3F);
    busRead(1'b0, 2'd0, 8'h3F, "R2 index readback");
    busRead(1'b0, 2'd1, 8'h00, "R2 index upper lane");
    busWrite(1'b0, 2'd2, 8'h05);
    busRead(1'b0, 2'd0, 8'h3F, "R2 upper lane write ignored");
    // R3: identification field
    setIndex(8'h00);
    busWrite(1'b1, 2'd3, 8'hA5);
    busRead(1'b1, 2'd3, 8'h05, "R3 id field");
    busWrite(1'b1, 2'd0, 8'hFF);
    busRead(1'b1, 2'd0, 8'h00, "R3 other bits zero");
    busRead(1'b1, 2'd3, 8'h05, "R3 id kept after lane0 write");
    // R4: version
    setIndex(8'h01);
    busWrite(1'b1, 2'd0, 8'h55);
    busRead(1'b1, 2'd0, 8'h11, "R4 version lane0");
    busRead(1'b1, 2'd2, 8'h17, "R4 max entry lane2");
    busRead(1'b1, 2'd1, 8'h00, "R4 lane1");
    // R5: arbitration
    setIndex(8'h02);
    busWrite(1'b1, 2'd3, 8'h0C);
    busRead(1'b1, 2'd3, 8'h05, "R5 arb mirrors id, write ignored");
    busRead(1'b1, 2'd0, 8'h00, "R5 arb lane0");
    // R6/R7: table first word
    setIndex(8'h10);
    busWrite(1'b1, 2'd0, 8'h31);
    busWrite(1'b1, 2'd1, 8'h42);
    busRead(1'b1, 2'd0, 8'h31, "R7 lane0 kept after lane1 write");
    busRead(1'b1, 2'd1, 8'h42, "R6 table lane1");
    busRead(1'b1, 2'd2, 8'h00, "R6 table lane2");
    setIndex(8'h11);
    busRead(1'b1, 2'd0, 8'h00, "R6 high half separate");
    // R6/R7: last table word
    setIndex(8'h3F);
    busWrite(1'b1, 2'd3, 8'h9C);
    busRead(1'b1, 2'd3, 8'h9C, "R6 last half lane3");
    busRead(1'b1, 2'd0, 8'h00, "R7 last half lane0 kept");
    @(negedge clk);
    checks++;
    if (mem[47] !== 32'h9C000000 || mem[0] !== 32'h00004231) begin
      fails++;
      $display("FAIL R6: mem47=%08h mem0=%08h expected=9c000000/00004231", mem[47], mem[0]);
    end
    // R8: unused indices
    setIndex(8'h05);
    busWrite(1'b1, 2'd0, 8'h77);
    busRead(1'b1, 2'd0, 8'h00, "R8 unused 0x05 reads zero");
    setIndex(8'h40);
    busWrite(1'b1, 2'd0, 8'h77);
    busRead(1'b1, 2'd0, 8'h00, "R8 unused 0x40 reads zero");
    @(negedge clk);
    checks++;
    if (wrPulses != 3) begin
      fails++;
      $display("FAIL R8: table write pulses=%0d expected=3", wrPulses);
    end
    setIndex(8'h00);
    busRead(1'b1, 2'd3, 8'h05, "R8 id untouched by unused writes");
    // R9: write without chip select
    setIndex(8'h02);
    busWrite(1'b0, 2'd0, 8'h10, 1'b0);
    busRead(1'b0, 2'd0, 8'h02, "R9 no write with csN high");
    // R10: no read strobe gives zero
    setIndex(8'h01);
    busRead(1'b1, 2'd0, 8'h00, "R10 rdN high reads zero", 1'b0);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule